// File: doc/BRIEF.md
# General-Purpose I/O Port with Peripheral Override

This block controls a port of eight I/O pins through a small byte-addressed register file. Software sets the value each pin drives, its direction, a reduced-drive option and a pull-device option, and reads back the pin levels after a two-flop synchronizer. The block produces the per-pin pad controls: drive value, output enable, reduced drive and pull enable.

The lower four pins can be given to a serial peripheral. While the peripheral claims a pin, the peripheral's own drive value and output enable decide the pad. If the peripheral uses that pin as an input, the pull-down is forced on. The synchronized levels of those pins are sent back to the peripheral.

A separate interrupt pin normally passes through the synchronizer. In stop mode, with the clock possibly halted, it bypasses the synchronizer so that a wake-up request can still reach the core.

Top module: `gpio_port`

## Requirements
- R1: After synchronous reset, the data, direction, reduced-drive and pull registers are zero, `pad_oe`, `pad_rdrv` and `pad_pull` are all zero, and `bus_rdata` is zero.
- R2: Offset 0 is data, 1 is direction, 3 is reduced drive and 4 is pull enable. A write at one of these offsets updates that register. A read at offset N returns on `bus_rdata` at the edge after the `bus_rd` cycle. Offsets 5 to 7 read as zero.
- R3: Offset 2 reads the pin levels through a two-stage synchronizer. A level held on `pad_in` for two rising edges appears in a read issued after them.
- R4: A read of offset 0 returns, bit by bit, the data register bit where the direction bit is 1, and the synchronized pin level where it is 0.
- R5: For pins 0 to 3 with `per_en` set, `pad_out` and `pad_oe` equal `per_dout` and `per_oe`. Without `per_en`, they equal the data and direction register bits.
- R6: Pins 4 to 7 always follow the data and direction registers, whatever the peripheral inputs are.
- R7: `pad_rdrv` of a pin is the reduced-drive register bit while that pin's effective output enable is 1. Otherwise it is 0.
- R8: `pad_pull` of a pin is 0 while its effective output enable is 1. Otherwise it is the pull register bit OR'd with (`per_en` AND NOT `per_oe`) for pins 0 to 3.
- R9: Writes to offset 2 and to offsets 5 to 7 change no register.
- R10: `pad_out` shows the data register even while the pin is an input. A value written before the direction is set to output is therefore on the pad in the first cycle the output enable is 1.
- R11: With `stop_mode` at 0, `irq_req` follows `irq_pin` after two rising edges. With `stop_mode` at 1, `irq_req` equals `irq_pin` with no clock.
- R12: `per_din` carries the synchronized levels of pins 0 to 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 3 | Byte offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| pad_in | input | 8 | Pin levels from the pads |
| pad_out | output | 8 | Drive value per pin |
| pad_oe | output | 8 | Output enable per pin |
| pad_rdrv | output | 8 | Reduced-drive select per pin |
| pad_pull | output | 8 | Pull-device enable per pin |
| per_en | input | 4 | Peripheral claims pins 0 to 3 |
| per_dout | input | 4 | Peripheral drive values |
| per_oe | input | 4 | Peripheral output enables |
| per_din | output | 4 | Synchronized levels for the peripheral |
| irq_pin | input | 1 | Asynchronous interrupt pin |
| stop_mode | input | 1 | Stop mode, selects the bypass |
| irq_req | output | 1 | Interrupt or wake request |

## Verification
The hardest case to reach is the interplay of the peripheral claim with the register-controlled qualifiers. The pull is forced only for claimed pins that the peripheral uses as inputs, and reduced drive must vanish when the peripheral turns a pin into an input. The bench programs four register configurations over the bus. Under each one it sweeps every combination of `per_en` and `per_oe` together with several `per_dout` patterns, and compares all four pad vectors with a model computed bit by bit. The stop-mode bypass is reached by raising `stop_mode` and checking `irq_req` within the same cycle, with no clock edge in between.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int ADDR_W = 3;
  typedef enum logic [ADDR_W-1:0] {
    OFS_DATA = 3'd0,
    OFS_DIR  = 3'd1,
    OFS_LVL  = 3'd2,
    OFS_RDRV = 3'd3,
    OFS_PULL = 3'd4
  } ofs_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 9,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  localparam int LAST = STAGES - 1;
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= '0;
    else     stg[0] <= din;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg[s] <= '0;
      else     stg[s] <= stg[s-1];
    end
  end

  assign dout = stg[LAST];
endmodule

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux #(
  parameter int W     = 8,
  parameter int SHARE = 4
) (
  input  logic [W-1:0]     reg_data,
  input  logic [W-1:0]     reg_dir,
  input  logic [W-1:0]     reg_rdrv,
  input  logic [W-1:0]     reg_pull,
  input  logic [SHARE-1:0] per_en,
  input  logic [SHARE-1:0] per_dout,
  input  logic [SHARE-1:0] per_oe,
  output logic [W-1:0]     pad_out,
  output logic [W-1:0]     pad_oe,
  output logic [W-1:0]     pad_rdrv,
  output logic [W-1:0]     pad_pull
);
  for (genvar i = 0; i < W; i++) begin : g_pin
    logic eff_o, eff_oe, force_pd;
    if (i < SHARE) begin : g_shared
      assign eff_o    = per_en[i] ? per_dout[i] : reg_data[i];
      assign eff_oe   = per_en[i] ? per_oe[i]   : reg_dir[i];
      assign force_pd = per_en[i] & ~per_oe[i];
    end else begin : g_plain
      assign eff_o    = reg_data[i];
      assign eff_oe   = reg_dir[i];
      assign force_pd = 1'b0;
    end
    assign pad_out[i]  = eff_o;
    assign pad_oe[i]   = eff_oe;
    assign pad_rdrv[i] = eff_oe & reg_rdrv[i];
    assign pad_pull[i] = ~eff_oe & (reg_pull[i] | force_pd);
  end

  // R7 / R8: qualifiers never active against the effective direction
  always_comb begin
    a_r7_rdrv_output_only: assert ((pad_rdrv & ~pad_oe) == '0);
    a_r8_pull_input_only:  assert ((pad_pull & pad_oe) == '0);
  end
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_pkg::*;
#(
  parameter int W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [W-1:0]      bus_wdata,
  output logic [W-1:0]      bus_rdata,
  input  logic [W-1:0]      lvl_sync,
  output logic [W-1:0]      reg_data,
  output logic [W-1:0]      reg_dir,
  output logic [W-1:0]      reg_rdrv,
  output logic [W-1:0]      reg_pull
);
  logic [W-1:0] rd_mux;

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_data <= '0;
      reg_dir  <= '0;
      reg_rdrv <= '0;
      reg_pull <= '0;
    end else if (bus_wr) begin
      case (bus_addr)
        OFS_DATA: reg_data <= bus_wdata;
        OFS_DIR:  reg_dir  <= bus_wdata;
        OFS_RDRV: reg_rdrv <= bus_wdata;
        OFS_PULL: reg_pull <= bus_wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (bus_addr)
      OFS_DATA: rd_mux = (reg_dir & reg_data) | (~reg_dir & lvl_sync);
      OFS_DIR:  rd_mux = reg_dir;
      OFS_LVL:  rd_mux = lvl_sync;
      OFS_RDRV: rd_mux = reg_rdrv;
      OFS_PULL: rd_mux = reg_pull;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end

  // R1: reset clears the whole register file
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (reg_data == '0 && reg_dir == '0 && reg_rdrv == '0 &&
             reg_pull == '0 && bus_rdata == '0));

  // R9: writes outside the writable offsets leave state untouched
  a_r9_ignored_write: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && (bus_addr == OFS_LVL || bus_addr > OFS_PULL)) |=>
    ($stable(reg_data) && $stable(reg_dir) && $stable(reg_rdrv) && $stable(reg_pull)));
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_pkg::*;
#(
  parameter int W      = 8,
  parameter int SHARE  = 4,
  parameter int STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [W-1:0]      bus_wdata,
  output logic [W-1:0]      bus_rdata,
  input  logic [W-1:0]      pad_in,
  output logic [W-1:0]      pad_out,
  output logic [W-1:0]      pad_oe,
  output logic [W-1:0]      pad_rdrv,
  output logic [W-1:0]      pad_pull,
  input  logic [SHARE-1:0]  per_en,
  input  logic [SHARE-1:0]  per_dout,
  input  logic [SHARE-1:0]  per_oe,
  output logic [SHARE-1:0]  per_din,
  input  logic              irq_pin,
  input  logic              stop_mode,
  output logic              irq_req
);
  localparam int SW = W + 1;

  logic [SW-1:0] sync_q;
  logic [W-1:0]  lvl_sync;
  logic          irq_sync;
  logic [W-1:0]  reg_data, reg_dir, reg_rdrv, reg_pull;

  gpio_sync #(.W(SW), .STAGES(STAGES)) i_sync (
    .clk(clk), .rst(rst), .din({irq_pin, pad_in}), .dout(sync_q)
  );

  assign lvl_sync = sync_q[W-1:0];
  assign irq_sync = sync_q[W];
  assign per_din  = lvl_sync[SHARE-1:0];
  assign irq_req  = stop_mode ? irq_pin : irq_sync;

  gpio_regs #(.W(W)) i_regs (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .lvl_sync(lvl_sync), .reg_data(reg_data), .reg_dir(reg_dir),
    .reg_rdrv(reg_rdrv), .reg_pull(reg_pull)
  );

  gpio_pin_mux #(.W(W), .SHARE(SHARE)) i_mux (
    .reg_data(reg_data), .reg_dir(reg_dir), .reg_rdrv(reg_rdrv),
    .reg_pull(reg_pull), .per_en(per_en), .per_dout(per_dout),
    .per_oe(per_oe), .pad_out(pad_out), .pad_oe(pad_oe),
    .pad_rdrv(pad_rdrv), .pad_pull(pad_pull)
  );

  // R6: pins above the shared range follow the registers only
  a_r6_plain_pins: assert property (@(posedge clk) disable iff (rst)
    (pad_oe[W-1:SHARE] == reg_dir[W-1:SHARE]) &&
    (pad_out[W-1:SHARE] == reg_data[W-1:SHARE]));

  // R5: an unclaimed shared pin is driven by the registers
  a_r5_unclaimed_regs: assert property (@(posedge clk) disable iff (rst)
    ((pad_oe[SHARE-1:0] ^ reg_dir[SHARE-1:0]) & ~per_en) == '0);

  // R11: a high pin in stop mode always requests wake
  a_r11_stop_wake: assert property (@(posedge clk) disable iff (rst)
    (stop_mode && irq_pin) |-> irq_req);
endmodule

// File: tb/test_gpio_port.sv
module test_gpio_port;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0, bus_rdata;
  logic [7:0] pad_in = '0, pad_out, pad_oe, pad_rdrv, pad_pull;
  logic [3:0] per_en = '0, per_dout = '0, per_oe = '0, per_din;
  logic       irq_pin = 1'b0, stop_mode = 1'b0, irq_req;

  int checks = 0;
  int errors = 0;
  logic done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_port i_gpio_port (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
    .pad_rdrv(pad_rdrv), .pad_pull(pad_pull), .per_en(per_en),
    .per_dout(per_dout), .per_oe(per_oe), .per_din(per_din),
    .irq_pin(irq_pin), .stop_mode(stop_mode), .irq_req(irq_req)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  // expected pad vectors from R5..R8
  task automatic check_pads(input logic [7:0] dt, input logic [7:0] dr,
                            input logic [7:0] rv, input logic [7:0] pl);
    logic [7:0] eo, eoe, erv, epl;
    for (int i = 0; i < 8; i++) begin
      logic claim, fpd;
      claim = (i < 4) && per_en[i];
      fpd = claim && !per_oe[i];
      eo[i]  = claim ? per_dout[i] : dt[i];
      eoe[i] = claim ? per_oe[i] : dr[i];
      erv[i] = eoe[i] & rv[i];
      epl[i] = !eoe[i] & (pl[i] | fpd);
    end
    check("R5/R6 pad_out", pad_out, eo);
    check("R5/R6 pad_oe", pad_oe, eoe);
    check("R7 pad_rdrv", pad_rdrv, erv);
    check("R8 pad_pull", pad_pull, epl);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    logic [7:0] v;
    logic [7:0] cfg_dt [4] = '{8'h00, 8'hA5, 8'h3C, 8'hFF};
    logic [7:0] cfg_dr [4] = '{8'h00, 8'hF0, 8'h5A, 8'hFF};
    logic [7:0] cfg_rv [4] = '{8'hFF, 8'h0F, 8'hC3, 8'h55};
    logic [7:0] cfg_pl [4] = '{8'hFF, 8'hAA, 8'h00, 8'h33};

    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 pad_oe", pad_oe, 8'h00);
    check("R1 pad_rdrv", pad_rdrv, 8'h00);
    check("R1 pad_pull", pad_pull, 8'h00);
    check("R1 rdata", bus_rdata, 8'h00);
    rst = 1'b0;
    rd(3'd1, v); check("R1 dir", v, 8'h00);
    rd(3'd3, v); check("R1 rdrv", v, 8'h00);
    rd(3'd4, v); check("R1 pull", v, 8'h00);

    // R2 write/read all writable offsets
    wr(3'd0, 8'h96); wr(3'd1, 8'hFF); wr(3'd3, 8'h5C); wr(3'd4, 8'hE1);
    rd(3'd0, v); check("R2 data", v, 8'h96);
    rd(3'd1, v); check("R2 dir", v, 8'hFF);
    rd(3'd3, v); check("R2 rdrv", v, 8'h5C);
    rd(3'd4, v); check("R2 pull", v, 8'hE1);
    for (int a = 5; a < 8; a++) begin
      rd(3'(a), v); check("R2 high offset reads zero", v, 8'h00);
    end

    // R9 ignored writes
    wr(3'd2, 8'h00);
    for (int a = 5; a < 8; a++) wr(3'(a), 8'h00);
    rd(3'd0, v); check("R9 data kept", v, 8'h96);
    rd(3'd1, v); check("R9 dir kept", v, 8'hFF);
    rd(3'd3, v); check("R9 rdrv kept", v, 8'h5C);
    rd(3'd4, v); check("R9 pull kept", v, 8'hE1);

    // R3 / R4 / R12 level readback sweep
    wr(3'd1, 8'h0F);
    for (int p = 0; p < 256; p += 17) begin
      @(negedge clk); pad_in = 8'(p);
      @(negedge clk); @(negedge clk);
      check("R12 per_din", {4'h0, per_din}, {4'h0, 4'(p)});
      rd(3'd2, v); check("R3 level", v, 8'(p));
      rd(3'd0, v); check("R4 mixed data read", v, (8'h96 & 8'h0F) | (8'(p) & 8'hF0));
    end
    // R3 latency: one edge is not enough
    @(negedge clk); pad_in = 8'h00;
    @(negedge clk); pad_in = 8'hFF;
    @(negedge clk);
    check("R12 per_din after one edge", {4'h0, per_din}, 8'h00);
    @(negedge clk);
    check("R12 per_din after two edges", {4'h0, per_din}, 8'h0F);

    // R10 data ahead of direction
    wr(3'd1, 8'h00); wr(3'd0, 8'h3B);
    #1 check("R10 pad_out while input", pad_out, 8'h3B);
    @(negedge clk); bus_wr = 1'b1; bus_addr = 3'd1; bus_wdata = 8'hFF;
    @(posedge clk); #1;
    check("R10 oe rises", pad_oe, 8'hFF);
    check("R10 data at oe rise", pad_out, 8'h3B);
    @(negedge clk); bus_wr = 1'b0;

    // R5-R8 sweep of peripheral claims over register configs
    for (int c = 0; c < 4; c++) begin
      wr(3'd0, cfg_dt[c]); wr(3'd1, cfg_dr[c]);
      wr(3'd3, cfg_rv[c]); wr(3'd4, cfg_pl[c]);
      for (int e = 0; e < 16; e++)
        for (int o = 0; o < 16; o++)
          for (int d = 0; d < 16; d += 5) begin
            per_en = 4'(e); per_oe = 4'(o); per_dout = 4'(d);
            #1 check_pads(cfg_dt[c], cfg_dr[c], cfg_rv[c], cfg_pl[c]);
          end
    end
    per_en = '0; per_oe = '0; per_dout = '0;

    // R11 interrupt path
    @(negedge clk); stop_mode = 1'b0; irq_pin = 1'b0;
    repeat (3) @(negedge clk);
    irq_pin = 1'b1;
    @(negedge clk); check("R11 sync one edge", {7'h0, irq_req}, 8'h00);
    @(negedge clk); check("R11 sync two edges", {7'h0, irq_req}, 8'h01);
    irq_pin = 1'b0;
    @(negedge clk); check("R11 sync hold", {7'h0, irq_req}, 8'h01);
    @(negedge clk); check("R11 sync fall", {7'h0, irq_req}, 8'h00);
    stop_mode = 1'b1;
    #1 irq_pin = 1'b1;
    #1 check("R11 stop bypass high", {7'h0, irq_req}, 8'h01);
    irq_pin = 1'b0;
    #1 check("R11 stop bypass low", {7'h0, irq_req}, 8'h00);
    stop_mode = 1'b0;

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule